// File: doc/BRIEF.md
# Memory-Indirect Effective Address Sequencer

This block works out the effective address of an operand that uses the full-format extension word. It covers three variants. Base-plus-index adds a base value, a scaled index and a base displacement. Pre-indexed applies the index before an indirect pointer read. Post-indexed applies the index after that read. The base is either an address register value or the program counter. The index register value and the instruction start address arrive as inputs. Operand values are sampled in the cycle the operation is started.

After a one-cycle `start`, the sequencer takes the extension word from a 16-bit instruction-word stream. It then takes any base displacement words and outer displacement words from the same stream, one word per cycle in which `ext_valid` is high. For the two indirect variants it makes exactly one 32-bit read over a request/acknowledge port to fetch the pointer. It ends with a one-cycle `done`, which shows the final address and the number of extension bytes consumed. The state walk is IDLE, READ_EXT, READ_BD, READ_OD, FETCH_PTR, DONE. Steps that do not apply are skipped.

Top module: `memind_addr_seq`

## Requirements
- R1: While reset is held, and whenever the block is idle, `busy`, `done`, `mem_req` and `ext_take` are all 0.
- R2: The bits of the extension word are assigned as follows:
  - bit 11: index width (1 = full 32 bits, 0 = low 16 bits sign-extended).
  - bits 10:9: scale code s.
  - bit 7: null base.
  - bit 6: null index.
  - bits 5:4: base displacement size.
  - bits 1:0: outer displacement size.
  - Size codes are: 00 or 01 = null, 10 = 16-bit sign-extended, 11 = 32-bit.
  - All other bits are ignored.
- R3: `mode` 00 and 11 select base-plus-index. The result is base + scaled index + base displacement, and no memory request is made.
- R4: `mode` 01 (pre-indexed) reads the pointer at base + scaled index + base displacement. The result is pointer + outer displacement.
- R5: `mode` 10 (post-indexed) reads the pointer at base + base displacement. The result is pointer + scaled index + outer displacement.
- R6: The index is either the full register or its low 16 bits sign-extended. It is then multiplied by 2^s.
- R7: A null base, null index or null displacement contributes 0. A null displacement takes no stream word.
- R8: `ext_bytes` is 2, plus 2 for each 16-bit displacement, plus 4 for each 32-bit displacement. The outer displacement field is ignored in base-plus-index mode: it adds no bytes and takes no words.
- R9: When `base_is_pc` is 1, the base is `inst_addr` + 2.
- R10: Stream words are taken in this order: the extension word, then the base displacement (high word first), then the outer displacement (high word first). `ext_take` is asserted only while `ext_valid` is high, and the sequencer waits through stalls.
- R11: `mem_req` and `mem_addr` stay stable until `mem_ack`. The pointer is captured in the acknowledge cycle. Exactly one read is made per indirect operation.
- R12: `done` is a one-cycle pulse. `start` is ignored while `busy` is high. Changes on the operand inputs after the start cycle do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mode | input | 2 | 00/11 base-plus-index, 01 pre-indexed, 10 post-indexed |
| base_is_pc | input | 1 | Use the program counter as the base |
| inst_addr | input | 32 | Start address of the instruction |
| areg_val | input | 32 | Base address register value |
| xreg_val | input | 32 | Index register value |
| ext_valid | input | 1 | Stream word present |
| ext_word | input | 16 | Current stream word |
| ext_take | output | 1 | Stream word consumed this cycle |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 32 | Pointer read address |
| mem_ack | input | 1 | Read acknowledge; data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid this cycle |
| ea_out | output | 32 | Final effective address |
| ext_bytes | output | 4 | Extension bytes consumed |

## Verification
Two events can fall in the same cycle: a fresh `start` and the `done` of the running operation, or a `start` during a pointer read that is still waiting for acknowledge. The bench drives `start` at random throughout every operation. It also changes the register and address inputs every cycle after the start cycle. Each operation must still end with a single `done`, with the address, byte count, stream words taken and read count all matching the values computed from the operands captured at start. A stray restart would show up as an extra word taken, an extra read or a wrong result.

// File: rtl/ams_pkg.sv
package ams_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 16;
  localparam int LEN_W  = 4;
  localparam int PC_OFS = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_EXT, ST_READ_BD, ST_READ_OD, ST_FETCH_PTR, ST_DONE
  } ams_state_e;

  typedef enum logic [1:0] {
    AM_BASE_INDEX = 2'b00, AM_PRE = 2'b01, AM_POST = 2'b10, AM_ALT = 2'b11
  } ams_mode_e;

  typedef struct packed {
    logic       idx_long;
    logic [1:0] scale;
    logic       base_null;
    logic       idx_null;
  } ext_fields_t;

  function automatic logic [ADDR_W-1:0] sext_word(input logic [WORD_W-1:0] w);
    return {{(ADDR_W-WORD_W){w[WORD_W-1]}}, w};
  endfunction

  function automatic logic [ADDR_W-1:0] scaled_index(input logic [ADDR_W-1:0] raw,
                                                     input logic is_long,
                                                     input logic [1:0] scale);
    logic [ADDR_W-1:0] v;
    v = is_long ? raw : sext_word(raw[WORD_W-1:0]);
    return v << scale;
  endfunction

  function automatic logic [1:0] size_to_words(input logic [1:0] sz);
    return (sz == 2'b11) ? 2'd2 : (sz == 2'b10) ? 2'd1 : 2'd0;
  endfunction

  function automatic logic is_indirect(input logic [1:0] m);
    return (m == AM_PRE) || (m == AM_POST);
  endfunction

  function automatic ams_state_e step_after(input logic [1:0] bd_w,
                                            input logic [1:0] od_w,
                                            input logic indirect);
    if (bd_w != 2'd0)    return ST_READ_BD;
    else if (od_w != 2'd0) return ST_READ_OD;
    else if (indirect)   return ST_FETCH_PTR;
    else                 return ST_DONE;
  endfunction

  function automatic logic [LEN_W-1:0] ext_len(input logic [1:0] bd_w,
                                               input logic [1:0] od_w);
    return LEN_W'(2) + {1'b0, bd_w, 1'b0} + {1'b0, od_w, 1'b0};
  endfunction
endpackage

// File: rtl/ams_ext_decode.sv
module ams_ext_decode
  import ams_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              indirect,
  output ext_fields_t       fields,
  output logic [1:0]        bd_words,
  output logic [1:0]        od_words
);
  logic unused_bits;
  assign unused_bits = ^{word[15:12], word[8], word[3:2]};

  assign fields.idx_long  = word[11];
  assign fields.scale     = word[10:9];
  assign fields.base_null = word[7];
  assign fields.idx_null  = word[6];
  assign bd_words = size_to_words(word[5:4]);
  assign od_words = indirect ? size_to_words(word[1:0]) : 2'd0;
endmodule

// File: rtl/ams_disp_reg.sv
module ams_disp_reg
  import ams_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        n_words,
  output logic [ADDR_W-1:0] value
);
  logic [ADDR_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc_q <= '0;
    else if (shift_en) acc_q <= {acc_q[ADDR_W-WORD_W-1:0], word};
  end

  always_comb begin
    unique case (n_words)
      2'd2:    value = acc_q;
      2'd1:    value = sext_word(acc_q[WORD_W-1:0]);
      default: value = '0;
    endcase
  end
endmodule

// File: rtl/ams_ptr_port.sv
module ams_ptr_port
  import ams_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              ptr_cap,
  output logic [ADDR_W-1:0] ptr_q
);
  assign mem_req  = active;
  assign mem_addr = active ? addr_in : '0;
  assign ptr_cap  = active && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (ptr_cap) ptr_q <= mem_rdata;
  end
endmodule

// File: rtl/memind_addr_seq.sv
module memind_addr_seq
  import ams_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              base_is_pc,
  input  logic [ADDR_W-1:0] inst_addr,
  input  logic [ADDR_W-1:0] areg_val,
  input  logic [ADDR_W-1:0] xreg_val,
  input  logic              ext_valid,
  input  logic [WORD_W-1:0] ext_word,
  output logic              ext_take,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] ea_out,
  output logic [LEN_W-1:0]  ext_bytes
);
  ams_state_e        state_q;
  logic [1:0]        mode_q;
  logic [ADDR_W-1:0] base_raw_q, idx_raw_q;
  ext_fields_t       fields_q;
  logic [1:0]        bd_w_q, od_w_q, left_q;

  // named internal events
  logic ev_accept, ev_ext_word, ev_bd_word, ev_od_word, ev_ptr_cap, direct_op;

  ext_fields_t       dec_fields;
  logic [1:0]        dec_bd_w, dec_od_w;
  logic [ADDR_W-1:0] bd_val, od_val, ptr_q, base_eff, idx_eff, inter_addr;
  logic              indirect;

  assign indirect    = is_indirect(mode_q);
  assign direct_op   = busy && !indirect;
  assign ev_accept   = (state_q == ST_IDLE) && start;
  assign ev_ext_word = (state_q == ST_READ_EXT) && ext_valid;
  assign ev_bd_word  = (state_q == ST_READ_BD) && ext_valid;
  assign ev_od_word  = (state_q == ST_READ_OD) && ext_valid;
  assign ext_take    = ev_ext_word || ev_bd_word || ev_od_word;
  assign busy        = (state_q != ST_IDLE);
  assign done        = (state_q == ST_DONE);

  ams_ext_decode u_dec (
    .word     (ext_word),
    .indirect (indirect),
    .fields   (dec_fields),
    .bd_words (dec_bd_w),
    .od_words (dec_od_w)
  );

  ams_disp_reg u_bd (
    .clk(clk), .rst_n(rst_n), .clr(ev_accept), .shift_en(ev_bd_word),
    .word(ext_word), .n_words(bd_w_q), .value(bd_val)
  );

  ams_disp_reg u_od (
    .clk(clk), .rst_n(rst_n), .clr(ev_accept), .shift_en(ev_od_word),
    .word(ext_word), .n_words(od_w_q), .value(od_val)
  );

  assign base_eff   = fields_q.base_null ? '0 : base_raw_q;
  assign idx_eff    = fields_q.idx_null ? '0
                    : scaled_index(idx_raw_q, fields_q.idx_long, fields_q.scale);
  assign inter_addr = base_eff + bd_val + ((mode_q == AM_PRE) ? idx_eff : '0);

  ams_ptr_port u_port (
    .clk(clk), .rst_n(rst_n), .active(state_q == ST_FETCH_PTR),
    .addr_in(inter_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .ptr_cap(ev_ptr_cap), .ptr_q(ptr_q)
  );

  always_comb begin
    unique case (mode_q)
      AM_PRE:  ea_out = ptr_q + od_val;
      AM_POST: ea_out = ptr_q + idx_eff + od_val;
      default: ea_out = base_eff + idx_eff + bd_val;
    endcase
  end
  assign ext_bytes = ext_len(bd_w_q, od_w_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      mode_q     <= AM_BASE_INDEX;
      base_raw_q <= '0;
      idx_raw_q  <= '0;
      fields_q   <= '0;
      bd_w_q     <= '0;
      od_w_q     <= '0;
      left_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          mode_q     <= mode;
          base_raw_q <= base_is_pc ? inst_addr + ADDR_W'(PC_OFS) : areg_val;
          idx_raw_q  <= xreg_val;
          state_q    <= ST_READ_EXT;
        end
        ST_READ_EXT: if (ext_valid) begin
          fields_q <= dec_fields;
          bd_w_q   <= dec_bd_w;
          od_w_q   <= dec_od_w;
          left_q   <= (dec_bd_w != 2'd0) ? dec_bd_w : dec_od_w;
          state_q  <= step_after(dec_bd_w, dec_od_w, indirect);
        end
        ST_READ_BD: if (ext_valid) begin
          if (left_q == 2'd1) begin
            left_q  <= od_w_q;
            state_q <= step_after(2'd0, od_w_q, indirect);
          end else begin
            left_q <= left_q - 2'd1;
          end
        end
        ST_READ_OD: if (ext_valid) begin
          if (left_q == 2'd1) state_q <= ST_FETCH_PTR;
          else                left_q  <= left_q - 2'd1;
        end
        ST_FETCH_PTR: if (mem_ack) state_q <= ST_DONE;
        ST_DONE:      state_q <= ST_IDLE;
        default:      state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ams_seq_chk.sv
module ams_seq_chk
  import ams_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ext_valid,
  input logic              ext_take,
  input logic [LEN_W-1:0]  ext_bytes,
  input logic              direct_op,
  input logic              ev_ptr_cap
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done && !ext_take));

  p_direct_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    direct_op |-> !mem_req);

  p_bytes_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ext_bytes >= LEN_W'(2) && ext_bytes <= LEN_W'(10) && !ext_bytes[0]));

  p_take_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_take |-> ext_valid);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_single_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);

  p_cap_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ptr_cap |=> done);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind memind_addr_seq ams_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .ext_valid(ext_valid),
  .ext_take(ext_take), .ext_bytes(ext_bytes), .direct_op(direct_op),
  .ev_ptr_cap(ev_ptr_cap)
);

// File: tb/memind_addr_seq_tb.sv
module memind_addr_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, start = 0, base_is_pc = 0;
  logic [1:0]  mode = 0;
  logic [31:0] inst_addr = 0, areg_val = 0, xreg_val = 0, mem_rdata = 0;
  logic        ext_valid = 0, mem_ack = 0;
  logic [15:0] ext_word = 0;
  logic        ext_take, mem_req, busy, done;
  logic [31:0] mem_addr, ea_out;
  logic [3:0]  ext_bytes;

  int checks = 0, errors = 0;

  memind_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base_is_pc(base_is_pc),
    .inst_addr(inst_addr), .areg_val(areg_val), .xreg_val(xreg_val),
    .ext_valid(ext_valid), .ext_word(ext_word), .ext_take(ext_take),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .ea_out(ea_out), .ext_bytes(ext_bytes)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] sx16(input logic [15:0] v);
    return $signed(v);
  endfunction

  function automatic logic [31:0] mem_img(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'hC3A5_0F96;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one complete operation with independently computed expectations
  task automatic run_op(input logic [1:0] m, input bit pc, input logic [31:0] ia,
                        input logic [31:0] ar, input logic [31:0] xr, input bit il,
                        input logic [1:0] sc, input bit bn, input bit inl,
                        input logic [1:0] bsz, input logic [31:0] bdr,
                        input logic [1:0] osz, input logic [31:0] odr, input string tag);
    logic [15:0] wq[0:5];
    int nw, widx, reads;
    bit ind, fin;
    logic [31:0] base, idx, bdv, odv, inter, ea;
    ind  = (m == 2'b01) || (m == 2'b10);
    base = bn ? 32'd0 : (pc ? ia + 32'd2 : ar);
    idx  = inl ? 32'd0 : (il ? xr : sx16(xr[15:0])) * (32'd1 << sc);
    bdv  = (bsz == 2'b11) ? bdr : (bsz == 2'b10) ? sx16(bdr[15:0]) : 32'd0;
    odv  = !ind ? 32'd0 : (osz == 2'b11) ? odr : (osz == 2'b10) ? sx16(odr[15:0]) : 32'd0;
    inter = (m == 2'b01) ? base + idx + bdv : base + bdv;
    if (m == 2'b01)      ea = mem_img(inter) + odv;
    else if (m == 2'b10) ea = mem_img(inter) + idx + odv;
    else                 ea = base + idx + bdv;
    // R2 layout: 11 long, 10:9 scale, 7 base null, 6 index null, 5:4 bd, 1:0 od
    wq[0] = {4'($urandom), il, sc, 1'($urandom), bn, inl, bsz, 2'($urandom), osz};
    nw = 1;
    if (bsz == 2'b11) begin wq[nw] = bdr[31:16]; wq[nw+1] = bdr[15:0]; nw += 2; end
    else if (bsz == 2'b10) begin wq[nw] = bdr[15:0]; nw++; end
    if (ind && osz == 2'b11) begin wq[nw] = odr[31:16]; wq[nw+1] = odr[15:0]; nw += 2; end
    else if (ind && osz == 2'b10) begin wq[nw] = odr[15:0]; nw++; end
    widx = 0; reads = 0; fin = 0;

    @(negedge clk);
    start = 1; mode = m; base_is_pc = pc; inst_addr = ia; areg_val = ar; xreg_val = xr;
    ext_valid = 0; mem_ack = 0;
    @(posedge clk);
    for (int cyc = 0; cyc < 200 && !fin; cyc++) begin
      @(negedge clk);
      // R12: restart attempts and operand churn while busy
      start = 1'($urandom); mode = 2'($urandom); base_is_pc = 1'($urandom);
      inst_addr = $urandom; areg_val = $urandom; xreg_val = $urandom;
      ext_valid = ($urandom % 4) != 0;
      ext_word  = (widx < nw) ? wq[widx] : 16'($urandom);
      mem_ack   = mem_req && (($urandom % 3) == 0);
      mem_rdata = mem_req ? mem_img(mem_addr) : $urandom;
      #1;
      if (ext_take) begin
        if (!ext_valid) chk("R10 take without valid", 32'(ext_take), 32'd0);
        widx++;
      end
      if (mem_req) begin
        chk(m == 2'b01 ? "R4 pointer address" : (m == 2'b10 ? "R5 pointer address" : "R3 no request"),
            mem_addr, ind ? inter : 32'hFFFF_FFFF);
        if (mem_ack) reads++;
      end
      if (done) begin
        fin = 1;
        start = 0;
        chk(tag, ea_out, ea);
        chk("R8 extension bytes", 32'(ext_bytes), 32'(2 * nw));
        chk("R7 words taken", 32'(widx), 32'(nw));
        chk("R11 read count", 32'(reads), ind ? 32'd1 : 32'd0);
      end
    end
    if (!fin) chk("R12 done never seen (watchdog)", 32'd0, 32'd1);
    start = 0;
    @(negedge clk); #1;
    chk("R12 done is one pulse", 32'(done), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    ext_valid = 1; start = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk("R1 busy in reset", 32'(busy), 0);
    chk("R1 done in reset", 32'(done), 0);
    chk("R1 mem_req in reset", 32'(mem_req), 0);
    chk("R1 ext_take in reset", 32'(ext_take), 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 idle ext_take", 32'(ext_take), 0);

    // R7: everything null, pre-indexed: pointer at 0, bytes 2
    run_op(2'b01, 0, 32'h1000, 32'h1234_5678, 32'h9, 1, 2'd3, 1, 1, 2'b01, 32'h0, 2'b00, 32'h0, "R7 all null");
    // R8: outer field ignored in base-plus-index mode, long bd
    run_op(2'b00, 0, 32'h0, 32'h0000_4000, 32'h10, 1, 2'd0, 0, 0, 2'b11, 32'h8000_0004, 2'b11, 32'hDEAD_BEEF, "R8 od ignored direct");
    // R9: PC base, post-indexed, word displacements negative
    run_op(2'b10, 1, 32'h0002_0000, 32'hFFFF_FFFF, 32'h0000_8002, 0, 2'd3, 0, 0, 2'b10, 32'h0000_FFF0, 2'b10, 32'h0000_8000, "R9 pc base");
    // R6: 16-bit index sign extension with scale 8
    run_op(2'b00, 0, 32'h0, 32'h0010_0000, 32'h1234_FFFE, 0, 2'd3, 0, 0, 2'b00, 32'h0, 2'b00, 32'h0, "R6 word index x8");
    // R3: mode 11 behaves as base-plus-index
    run_op(2'b11, 0, 32'h0, 32'hA000_0000, 32'h3, 1, 2'd1, 0, 0, 2'b10, 32'h7FFF, 2'b10, 32'h1, "R3 alt mode");
    // R4: pre-indexed with both displacements long
    run_op(2'b01, 0, 32'h0, 32'h0000_1000, 32'h20, 1, 2'd2, 0, 0, 2'b11, 32'h1111_2222, 2'b11, 32'h3333_4444, "R4 long both");
    // R5: post-indexed, null base register, long outer
    run_op(2'b10, 0, 32'h0, 32'h5555_5555, 32'h8000_0000, 1, 2'd0, 1, 0, 2'b01, 32'h0, 2'b11, 32'h0F0F_0F0F, "R5 null base");

    for (int n = 0; n < 400; n++) begin
      logic [1:0] m;
      m = 2'($urandom);
      run_op(m, 1'($urandom), {$urandom} & 32'hFFFF_FFFE, $urandom, $urandom,
             1'($urandom), 2'($urandom), ($urandom % 5) == 0, ($urandom % 5) == 0,
             2'($urandom), $urandom, 2'($urandom), $urandom,
             m == 2'b01 ? "R4 random" : (m == 2'b10 ? "R5 random" : "R3 random"));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule